// File: doc/BRIEF.md
# Two-level write-one-to-clear interrupt collector

The block gathers raw event pulses from a set of sources into a first-level identity register. Each source is qualified by its own mask bit and its own enable bit. The identity register is double buffered: an event that arrives while a source's bit is already set is held in a hidden slot. That slot reloads the visible bit when software clears it, so a busy source needs two clears before it reads empty. The OR of the identity bits is the first-level pending summary.

A display control register carries a gate bit. The summary ANDed with the gate is watched for rising edges, and each rising edge sets a single-buffered, write-one-to-clear bit in a master status register. The interrupt line is a registered OR of the master status. One clear write empties the master bit however many edges came before it. A source that stays pending while the gate is held high raises nothing more once the master bit has been cleared. A new interrupt then needs a fresh edge, for example the gate being turned off and on again.

Top module: `irq_agg`

## Requirements
- R1: After reset the mask register (address 0) reads all ones in its NSRC bits, and the enable register (1), the identity register (2), the master status register (4) and irq_o all read 0.
- R2: An event pulse on evt_i[i] sets identity bit i only when mask bit i is 0 and enable bit i is 1. In every other case the pulse leaves the identity register unchanged.
- R3: The identity register is double buffered. A qualified event that arrives while its bit is already set is queued. A write of 1 to that bit at address 2 reloads the bit from the queue, so a bit with one queued event needs two such writes to read 0.
- R4: A read of the display control register (address 3) returns the stored gate in bit 31 and the OR of the identity bits in bit 16. All other bits read 0. Only bit 31 is writable.
- R5: Master status bit 16 (address 4) is set at the clock edge after the edge where (gate AND summary) goes from 0 to 1. It is not set while the gate is 0.
- R6: Turning the gate off and on again while the summary stays 1 gives a new edge, which sets master bit 16 again.
- R7: One write with bit 16 set at address 4 clears master bit 16, even after several edges have set it.
- R8: While the gate and the summary both stay at 1, master bit 16 stays at 0 after a clear, because no new edge occurs.
- R9: When a master set and a clear write reach bit 16 in the same cycle, the bit ends up set.
- R10: irq_o equals, one cycle later, the OR of the master status bits.
- R11: The mask (0) and enable (1) registers read back what was last written in their NSRC bits. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NSRC | One-cycle event pulses, one per source |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 1 | Registered interrupt output |

## Verification
A wrong queued slot in the identity register stays hidden until a clear. It then shows as a bit that reads 1 or 0 on address 2 in the cycle after the write, so the bench clears busy bits twice and reads after each clear. A wrong edge detector state shows one cycle after a gate change as a master bit that is missing or set, and two cycles later on irq_o. The bench compares the read data and the interrupt against a reference model on every clock, so either fault is seen within three cycles of its cause.

// File: rtl/irq_agg.sv
module irq_agg #(
  parameter int NSRC = 8,
  parameter int DISP_BIT = 16,
  parameter int GATE_BIT = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            bus_wr,
  input  logic [2:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_o
);
  localparam logic [2:0] A_MASK = 3'd0, A_EN = 3'd1, A_IDENT = 3'd2,
                         A_DCTL = 3'd3, A_MSTAT = 3'd4;

  logic [NSRC-1:0] mask_q, en_q, vis_q, que_q;
  logic            gate_q, gated_d, mstat_q;

  wire [NSRC-1:0] hit  = evt_i & ~mask_q & en_q;
  wire [NSRC-1:0] clr  = (bus_wr && bus_addr == A_IDENT) ? bus_wdata[NSRC-1:0] : '0;
  wire            pend = |vis_q;
  wire            gated = gate_q & pend;
  wire            rise = gated & ~gated_d;
  wire            mclr = bus_wr && bus_addr == A_MSTAT && bus_wdata[DISP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      en_q   <= '0;
      gate_q <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == A_MASK) mask_q <= bus_wdata[NSRC-1:0];
      if (bus_addr == A_EN)   en_q   <= bus_wdata[NSRC-1:0];
      if (bus_addr == A_DCTL) gate_q <= bus_wdata[GATE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q <= '0;
      que_q <= '0;
    end else begin
      vis_q <= (clr & (que_q | hit)) | (~clr & (vis_q | hit));
      que_q <= (clr & que_q & hit) | (~clr & (que_q | (vis_q & hit)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gated_d <= 1'b0;
      mstat_q <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      gated_d <= gated;
      mstat_q <= rise | (mstat_q & ~mclr);
      irq_o   <= mstat_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MASK:  bus_rdata[NSRC-1:0] = mask_q;
      A_EN:    bus_rdata[NSRC-1:0] = en_q;
      A_IDENT: bus_rdata[NSRC-1:0] = vis_q;
      A_DCTL: begin
        bus_rdata[GATE_BIT] = gate_q;
        bus_rdata[DISP_BIT] = pend;
      end
      A_MSTAT: bus_rdata[DISP_BIT] = mstat_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module irq_agg_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] vis,
  input logic [NSRC-1:0] que,
  input logic            gate,
  input logic            mstat,
  input logic            mclr,
  input logic            irq
);
  wire gated = gate & (|vis);

  // R3
  queue_behind_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (que & ~vis) == '0);

  // R10
  irq_follows_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(mstat));

  // R5
  no_set_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mstat && !(gated && !$past(gated))) |=> !mstat);

  // R9
  edge_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !$past(gated)) |=> mstat);

  // R7
  clear_empties_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr && !(gated && !$past(gated))) |=> !mstat);
endmodule

bind irq_agg irq_agg_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .vis(vis_q), .que(que_q), .gate(gate_q),
  .mstat(mstat_q), .mclr(mclr), .irq(irq_o)
);

// File: tb/irq_agg_bench.sv
`timescale 1ns/1ps
module irq_agg_bench;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] evt = '0;
  logic wr = 0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  irq_agg #(.NSRC(N)) u_irq_agg (.clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0;
  string tag = "R1";

  int m_mask, m_en, m_gate, m_mstat, m_irq, m_prevgate;
  int cnt[N];

  function automatic int m_pend();
    for (int i = 0; i < N; i++) if (cnt[i] > 0) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    logic [31:0] r = '0;
    case (a)
      3'd0: r = m_mask;
      3'd1: r = m_en;
      3'd2: for (int i = 0; i < N; i++) r[i] = (cnt[i] > 0);
      3'd3: begin r[31] = m_gate[0]; r[16] = m_pend() != 0; end
      3'd4: r[16] = m_mstat[0];
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = (1 << N) - 1; m_en = 0; m_gate = 0; m_mstat = 0; m_irq = 0; m_prevgate = 0;
      for (int i = 0; i < N; i++) cnt[i] = 0;
    end else begin
      int g, rise;
      g = (m_gate != 0 && m_pend() != 0) ? 1 : 0;
      rise = (g == 1 && m_prevgate == 0) ? 1 : 0;
      m_irq = m_mstat;
      for (int i = 0; i < N; i++) begin
        if (wr && addr == 3'd2 && wdata[i] && cnt[i] > 0) cnt[i] = cnt[i] - 1;
        if (evt[i] && !m_mask[i] && m_en[i] && cnt[i] < 2) cnt[i] = cnt[i] + 1;
      end
      if (wr && addr == 3'd4 && wdata[16]) m_mstat = 0;
      if (rise == 1) m_mstat = 1;
      m_prevgate = g;
      if (wr && addr == 3'd0) m_mask = int'(wdata[N-1:0]);
      if (wr && addr == 3'd1) m_en = int'(wdata[N-1:0]);
      if (wr && addr == 3'd3) m_gate = wdata[31];
    end
  end

  always @(negedge clk) if (rst_n) begin
    compared++;
    if (rdata !== m_read(addr) || irq !== m_irq[0]) begin
      mismatched++;
      $display("FAIL %s model: rdata=%h irq=%b expected rdata=%h irq=%0d",
               tag, rdata, irq, m_read(addr), m_irq);
    end
  end

  task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                      input logic [N-1:0] e);
    wr = w; addr = a; wdata = d; evt = e;
    @(negedge clk); #1;
    wr = 0; evt = '0;
  endtask

  task automatic put(input logic [2:0] a, input logic [31:0] d);
    step(1'b1, a, d, '0);
  endtask

  task automatic pulse(input logic [N-1:0] e);
    step(1'b0, 3'd7, 32'h0, e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd7, 32'h0, '0);
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] exp, input string t);
    wr = 0; addr = a;
    @(negedge clk);
    compared++;
    if (rdata !== exp) begin
      mismatched++;
      $display("FAIL %s addr %0d: actual %h expected %h", t, a, rdata, exp);
    end
    #1;
  endtask

  task automatic expect_irq(input logic exp, input string t);
    @(negedge clk);
    compared++;
    if (irq !== exp) begin
      mismatched++;
      $display("FAIL %s irq: actual %b expected %b", t, irq, exp);
    end
    #1;
  endtask

  initial begin
    #100000000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    tag = "R1";
    expect_rd(3'd0, 32'h0000_00FF, "R1");
    expect_rd(3'd1, 32'h0, "R1");
    expect_rd(3'd2, 32'h0, "R1");
    expect_rd(3'd4, 32'h0, "R1");
    expect_irq(1'b0, "R1");

    tag = "R11";
    put(3'd1, 32'h0000_0003);
    put(3'd0, 32'hFFFF_FFFC);
    expect_rd(3'd1, 32'h0000_0003, "R11");
    expect_rd(3'd0, 32'h0000_00FC, "R11");
    expect_rd(3'd6, 32'h0, "R11");

    tag = "R2";
    pulse(8'h04);
    expect_rd(3'd2, 32'h0, "R2");
    put(3'd0, 32'h0000_00FE);
    pulse(8'h02);
    expect_rd(3'd2, 32'h0, "R2");
    pulse(8'h01);
    expect_rd(3'd2, 32'h1, "R2");

    tag = "R4";
    expect_rd(3'd3, 32'h0001_0000, "R4");

    tag = "R3";
    pulse(8'h01);
    put(3'd2, 32'h1);
    expect_rd(3'd2, 32'h1, "R3");
    put(3'd2, 32'h1);
    expect_rd(3'd2, 32'h0, "R3");
    expect_rd(3'd3, 32'h0, "R4");

    tag = "R5";
    put(3'd3, 32'h8000_0000);
    idle(2);
    expect_rd(3'd4, 32'h0, "R5");
    pulse(8'h01);
    idle(1);
    expect_rd(3'd4, 32'h0001_0000, "R5");
    expect_rd(3'd3, 32'h8001_0000, "R4");
    expect_irq(1'b1, "R10");

    tag = "R6";
    put(3'd3, 32'h0);
    put(3'd3, 32'h8000_0000);
    put(3'd3, 32'h0);
    put(3'd3, 32'h8000_0000);
    idle(2);
    tag = "R7";
    put(3'd4, 32'hFFFF_FFFF);
    expect_rd(3'd4, 32'h0, "R7");
    expect_irq(1'b0, "R10");

    tag = "R8";
    idle(3);
    expect_rd(3'd4, 32'h0, "R8");
    expect_irq(1'b0, "R8");

    tag = "R6";
    put(3'd3, 32'h0);
    put(3'd3, 32'h8000_0000);
    idle(1);
    expect_rd(3'd4, 32'h0001_0000, "R6");
    put(3'd4, 32'h0001_0000);
    expect_rd(3'd4, 32'h0, "R7");

    tag = "R9";
    put(3'd3, 32'h0);
    put(3'd3, 32'h8000_0000);
    put(3'd4, 32'h0001_0000);
    expect_rd(3'd4, 32'h0001_0000, "R9");
    idle(1);
    expect_irq(1'b1, "R10");

    tag = "R3";
    put(3'd2, 32'hFF);
    put(3'd4, 32'hFFFF_FFFF);
    expect_rd(3'd2, 32'h0, "R3");
    idle(3);
    expect_irq(1'b0, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule